// File: doc/BRIEF.md
# UART FIFO Trigger Threshold Controller

This block chooses, for one UART channel, the fill thresholds that decide when the channel asks for service. The inputs are a compatibility mode code, an enhanced-operation flag, the FIFO control byte and a set of software-programmable threshold values. From these it selects four values: the transmit threshold, the receive upper threshold, the receive lower threshold and the effective FIFO depth. The upper and lower receive thresholds are kept apart so that flow control can use them with hysteresis.

The block also compares the live transmit and receive fill counts against the chosen thresholds. It raises a transmit-service request when the transmit count is below its threshold, and a receive-data request when the receive count has reached the upper threshold. Each request is only raised when its enable input is set.

All six outputs are registered and recomputed on every clock. A change of mode, control byte or fill count shows at the outputs one clock later. The FIFO storage, the serial shifters and the flow-control character handling live outside this block and use its outputs.

Top module: `trig_level_ctrl`

## Requirements
- R1: While reset is asserted, every threshold output, the depth output and both requests are 0.
- R2: Mode code 0 (byte mode) selects a transmit threshold of 1, upper and lower receive thresholds of 1 and a depth of 1. Codes 6 and 7 behave the same way.
- R3: Mode code 1 sets the transmit threshold to 1. Control bits [7:6] values 0, 1, 2 and 3 select an upper receive threshold of 1, 4, 8 and 14. The lower threshold is 0 (unused).
- R4: Mode codes 2 and 4 set the transmit threshold to 1 and the lower receive threshold to 1. Control bits [7:6] values 0, 1, 2 and 3 select an upper threshold of 1, 32, 64 and 112.
- R5: In mode code 3, control bits [7:6] values 0, 1, 2 and 3 select upper receive thresholds of 16, 32, 112 and 120, and lower thresholds of 1, 16, 32 and 112.
- R6: In mode code 3, when the enhanced flag is set and control bit 3 is 1, control bits [5:4] values 0, 1, 2 and 3 select transmit thresholds of 16, 32, 64 and 112. In every other case the transmit threshold is 1.
- R7: The depth is 16 in mode 1, except that it is 128 when the enhanced flag and control bit 0 are both set. In mode 4 with the enhanced flag clear, control bit 5 picks 16 (0) or 128 (1). In mode 4 with the enhanced flag set, control bit 0 picks 16 (0) or 128 (1). Modes 2, 3 and 5 have a depth of 128.
- R8: Mode code 5 takes the transmit, upper and lower thresholds from the programmable inputs, ignores all control trigger bits, and has a depth of 128.
- R9: The transmit request is 1 exactly when its enable was set and the transmit fill count was below the transmit threshold.
- R10: The receive request is 1 exactly when its enable was set and the receive fill count was at or above the upper receive threshold.
- R11: Outputs follow the inputs sampled at the previous rising clock edge. An input change made between edges is not visible before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_mode | input | 3 | Compatibility mode code (0..5, 6 and 7 act as 0) |
| enh_mode | input | 1 | Enhanced-operation flag |
| fifo_ctl | input | 8 | FIFO control byte (trigger fields, DMA select, depth bits) |
| prog_tx_lvl | input | LVL_W | Programmable transmit threshold |
| prog_rx_hi | input | LVL_W | Programmable upper receive threshold |
| prog_rx_lo | input | LVL_W | Programmable lower receive threshold |
| tx_fill | input | LVL_W | Current transmit FIFO fill count |
| rx_fill | input | LVL_W | Current receive FIFO fill count |
| tx_irq_en | input | 1 | Transmit request enable |
| rx_irq_en | input | 1 | Receive request enable |
| tx_lvl | output | LVL_W | Active transmit threshold |
| rx_hi_lvl | output | LVL_W | Active upper receive threshold |
| rx_lo_lvl | output | LVL_W | Active lower receive threshold |
| fifo_depth | output | LVL_W | Effective FIFO depth |
| tx_irq | output | 1 | Transmit-service request |
| rx_irq | output | 1 | Receive-data request |

## Verification
Two things can happen in the same cycle. A threshold can change because the mode or control byte changed, and the fill counts can be compared against that new threshold. Both requests can also rise together. To provoke this, the stimulus writes a new mode and control byte together with fill counts placed one below, exactly at, and one above the thresholds that the new settings select. A behavioural reference computes the thresholds and requests from the inputs seen at each rising edge. Every output is compared with that reference at the following falling edge, so a request judged against a stale threshold is reported.

// File: rtl/trig_lvl_pkg.sv
package trig_lvl_pkg;

  typedef enum logic [2:0] {
    CM_450  = 3'd0,
    CM_550  = 3'd1,
    CM_X550 = 3'd2,
    CM_650  = 3'd3,
    CM_750  = 3'd4,
    CM_950  = 3'd5
  } compat_mode_e;

  localparam int DEPTH_BYTE  = 1;
  localparam int DEPTH_SMALL = 16;
  localparam int DEPTH_LARGE = 128;

  // upper receive threshold, 16-deep table
  function automatic int rx_hi_small(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // upper receive threshold, 128-deep plain table
  function automatic int rx_hi_wide(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 32;
      2'd2:    return 64;
      default: return 112;
    endcase
  endfunction

  // upper receive threshold, code 3 mode
  function automatic int rx_hi_enh(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 32;
      2'd2:    return 112;
      default: return 120;
    endcase
  endfunction

  // lower (hysteresis) threshold, code 3 mode
  function automatic int rx_lo_enh(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 112;
    endcase
  endfunction

  // transmit threshold, code 3 mode with DMA select
  function automatic int tx_enh(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 32;
      2'd2:    return 64;
      default: return 112;
    endcase
  endfunction

endpackage

// File: rtl/trig_tx_sel.sv
module trig_tx_sel
  import trig_lvl_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic [2:0]       mode_i,
  input  logic             enh_i,
  input  logic             dma1_i,
  input  logic [1:0]       code_i,
  input  logic [LVL_W-1:0] prog_i,
  output logic [LVL_W-1:0] lvl_o
);

  always_comb begin
    lvl_o = LVL_W'(1);
    case (mode_i)
      CM_650: begin
        if (enh_i && dma1_i) lvl_o = LVL_W'(tx_enh(code_i));
      end
      CM_950:  lvl_o = prog_i;
      default: lvl_o = LVL_W'(1);
    endcase
  end

endmodule

// File: rtl/trig_rx_sel.sv
module trig_rx_sel
  import trig_lvl_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic [2:0]       mode_i,
  input  logic [1:0]       code_i,
  input  logic [LVL_W-1:0] prog_hi_i,
  input  logic [LVL_W-1:0] prog_lo_i,
  output logic [LVL_W-1:0] hi_o,
  output logic [LVL_W-1:0] lo_o
);

  always_comb begin
    hi_o = LVL_W'(1);
    lo_o = LVL_W'(1);
    case (mode_i)
      CM_550: begin
        hi_o = LVL_W'(rx_hi_small(code_i));
        lo_o = '0;
      end
      CM_X550, CM_750: begin
        hi_o = LVL_W'(rx_hi_wide(code_i));
        lo_o = LVL_W'(1);
      end
      CM_650: begin
        hi_o = LVL_W'(rx_hi_enh(code_i));
        lo_o = LVL_W'(rx_lo_enh(code_i));
      end
      CM_950: begin
        hi_o = prog_hi_i;
        lo_o = prog_lo_i;
      end
      default: begin
        hi_o = LVL_W'(1);
        lo_o = LVL_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/trig_depth_sel.sv
module trig_depth_sel
  import trig_lvl_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic [2:0]       mode_i,
  input  logic             enh_i,
  input  logic             fifo_on_i,
  input  logic             size_bit_i,
  output logic [LVL_W-1:0] depth_o
);

  localparam logic [LVL_W-1:0] D_BYTE  = LVL_W'(DEPTH_BYTE);
  localparam logic [LVL_W-1:0] D_SMALL = LVL_W'(DEPTH_SMALL);
  localparam logic [LVL_W-1:0] D_LARGE = LVL_W'(DEPTH_LARGE);

  logic enh_large;
  assign enh_large = enh_i && fifo_on_i;

  always_comb begin
    depth_o = D_BYTE;
    case (mode_i)
      CM_550:  depth_o = enh_large ? D_LARGE : D_SMALL;
      CM_750: begin
        if (enh_i) depth_o = fifo_on_i  ? D_LARGE : D_SMALL;
        else       depth_o = size_bit_i ? D_LARGE : D_SMALL;
      end
      CM_X550, CM_650, CM_950: depth_o = D_LARGE;
      default: depth_o = D_BYTE;
    endcase
  end

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp #(
  parameter int LVL_W = 8,
  parameter bit BELOW = 1'b1
) (
  input  logic             en_i,
  input  logic [LVL_W-1:0] fill_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             req_o
);

  generate
    if (BELOW) begin : g_below
      assign req_o = en_i && (fill_i < lvl_i);
    end else begin : g_reach
      assign req_o = en_i && (fill_i >= lvl_i);
    end
  endgenerate

endmodule

// File: rtl/trig_level_ctrl.sv
module trig_level_ctrl #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       compat_mode,
  input  logic             enh_mode,
  input  logic [7:0]       fifo_ctl,
  input  logic [LVL_W-1:0] prog_tx_lvl,
  input  logic [LVL_W-1:0] prog_rx_hi,
  input  logic [LVL_W-1:0] prog_rx_lo,
  input  logic [LVL_W-1:0] tx_fill,
  input  logic [LVL_W-1:0] rx_fill,
  input  logic             tx_irq_en,
  input  logic             rx_irq_en,
  output logic [LVL_W-1:0] tx_lvl,
  output logic [LVL_W-1:0] rx_hi_lvl,
  output logic [LVL_W-1:0] rx_lo_lvl,
  output logic [LVL_W-1:0] fifo_depth,
  output logic             tx_irq,
  output logic             rx_irq
);

  // control byte field positions
  localparam int FC_ON   = 0;
  localparam int FC_DMA  = 3;
  localparam int FC_TXLO = 4;
  localparam int FC_SIZE = 5;
  localparam int FC_RXLO = 6;

  logic [LVL_W-1:0] tx_lvl_d, rx_hi_d, rx_lo_d, depth_d;
  logic             tx_req_d, rx_req_d;
  logic             upd_en;

  assign upd_en = 1'b1;

  trig_tx_sel #(.LVL_W(LVL_W)) u_tx_sel (
    .mode_i (compat_mode),
    .enh_i  (enh_mode),
    .dma1_i (fifo_ctl[FC_DMA]),
    .code_i (fifo_ctl[FC_TXLO+1:FC_TXLO]),
    .prog_i (prog_tx_lvl),
    .lvl_o  (tx_lvl_d)
  );

  trig_rx_sel #(.LVL_W(LVL_W)) u_rx_sel (
    .mode_i    (compat_mode),
    .code_i    (fifo_ctl[FC_RXLO+1:FC_RXLO]),
    .prog_hi_i (prog_rx_hi),
    .prog_lo_i (prog_rx_lo),
    .hi_o      (rx_hi_d),
    .lo_o      (rx_lo_d)
  );

  trig_depth_sel #(.LVL_W(LVL_W)) u_depth_sel (
    .mode_i     (compat_mode),
    .enh_i      (enh_mode),
    .fifo_on_i  (fifo_ctl[FC_ON]),
    .size_bit_i (fifo_ctl[FC_SIZE]),
    .depth_o    (depth_d)
  );

  trig_cmp #(.LVL_W(LVL_W), .BELOW(1'b1)) u_tx_cmp (
    .en_i   (tx_irq_en),
    .fill_i (tx_fill),
    .lvl_i  (tx_lvl_d),
    .req_o  (tx_req_d)
  );

  trig_cmp #(.LVL_W(LVL_W), .BELOW(1'b0)) u_rx_cmp (
    .en_i   (rx_irq_en),
    .fill_i (rx_fill),
    .lvl_i  (rx_hi_d),
    .req_o  (rx_req_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lvl     <= '0;
      rx_hi_lvl  <= '0;
      rx_lo_lvl  <= '0;
      fifo_depth <= '0;
      tx_irq     <= 1'b0;
      rx_irq     <= 1'b0;
    end else if (upd_en) begin
      tx_lvl     <= tx_lvl_d;
      rx_hi_lvl  <= rx_hi_d;
      rx_lo_lvl  <= rx_lo_d;
      fifo_depth <= depth_d;
      tx_irq     <= tx_req_d;
      rx_irq     <= rx_req_d;
    end
  end

  AST_BYTE_MODE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(compat_mode) == 3'd0) |->
      (tx_lvl == LVL_W'(1) && rx_hi_lvl == LVL_W'(1) && rx_lo_lvl == LVL_W'(1) && fifo_depth == LVL_W'(1))); // R2

  AST_PROG_TX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(compat_mode) == 3'd5) |-> (tx_lvl == $past(prog_tx_lvl))); // R8

  AST_DEPTH_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(fifo_depth) == 1)); // R7

  AST_TX_REQ_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> ($past(tx_fill) < tx_lvl)); // R9

  AST_TX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tx_irq_en)) |-> !tx_irq); // R9

  AST_RX_REQ_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> ($past(rx_fill) >= rx_hi_lvl)); // R10

  AST_RX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rx_irq_en)) |-> !rx_irq); // R10

endmodule

// File: tb/trig_level_ctrl_tb.sv
module trig_level_ctrl_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   compat_mode;
  logic         enh_mode;
  logic [7:0]   fifo_ctl;
  logic [W-1:0] prog_tx_lvl, prog_rx_hi, prog_rx_lo, tx_fill, rx_fill;
  logic         tx_irq_en, rx_irq_en;
  logic [W-1:0] tx_lvl, rx_hi_lvl, rx_lo_lvl, fifo_depth;
  logic         tx_irq, rx_irq;

  int n_chk = 0;
  int n_err = 0;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  int exp_tx, exp_hi, exp_lo, exp_dep, exp_tirq, exp_rirq, exp_mode;

  always #5 clk = ~clk;

  trig_level_ctrl #(.LVL_W(W)) u_dut (
    .clk, .rst_n, .compat_mode, .enh_mode, .fifo_ctl,
    .prog_tx_lvl, .prog_rx_hi, .prog_rx_lo, .tx_fill, .rx_fill,
    .tx_irq_en, .rx_irq_en, .tx_lvl, .rx_hi_lvl, .rx_lo_lvl,
    .fifo_depth, .tx_irq, .rx_irq
  );

  // behavioural reference tables
  function automatic int ref_tx(int m, bit e, int f, int p);
    int t[4] = '{16, 32, 64, 112};
    if (m == 3) return (e && f[3]) ? t[(f >> 4) & 3] : 1;
    if (m == 5) return p;
    return 1;
  endfunction

  function automatic int ref_hi(int m, int f, int p);
    int c = (f >> 6) & 3;
    int a[4] = '{1, 4, 8, 14};
    int b[4] = '{1, 32, 64, 112};
    int d[4] = '{16, 32, 112, 120};
    case (m)
      1: return a[c];
      2, 4: return b[c];
      3: return d[c];
      5: return p;
      default: return 1;
    endcase
  endfunction

  function automatic int ref_lo(int m, int f, int p);
    int l[4] = '{1, 16, 32, 112};
    case (m)
      1: return 0;
      3: return l[(f >> 6) & 3];
      5: return p;
      default: return 1;
    endcase
  endfunction

  function automatic int ref_dep(int m, bit e, int f);
    case (m)
      1: return (e && f[0]) ? 128 : 16;
      4: return e ? (f[0] ? 128 : 16) : (f[5] ? 128 : 16);
      2, 3, 5: return 128;
      default: return 1;
    endcase
  endfunction

  function automatic string tag_tx(int m);
    case (m)
      1: return "R3";
      2, 4: return "R4";
      3: return "R6";
      5: return "R8";
      default: return "R2";
    endcase
  endfunction

  function automatic string tag_rx(int m);
    case (m)
      1: return "R3";
      2, 4: return "R4";
      3: return "R5";
      5: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  // reference model: evaluated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_tx = 0; exp_hi = 0; exp_lo = 0; exp_dep = 0;
      exp_tirq = 0; exp_rirq = 0; exp_mode = 0;
    end else begin
      exp_mode = int'(compat_mode);
      exp_tx   = ref_tx(exp_mode, enh_mode, int'(fifo_ctl), int'(prog_tx_lvl));
      exp_hi   = ref_hi(exp_mode, int'(fifo_ctl), int'(prog_rx_hi));
      exp_lo   = ref_lo(exp_mode, int'(fifo_ctl), int'(prog_rx_lo));
      exp_dep  = ref_dep(exp_mode, enh_mode, int'(fifo_ctl));
      exp_tirq = (tx_irq_en && int'(tx_fill) < exp_tx) ? 1 : 0;
      exp_rirq = (rx_irq_en && int'(rx_fill) >= exp_hi) ? 1 : 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (run_chk) begin
      chk(tag_tx(exp_mode), "tx_lvl", int'(tx_lvl), exp_tx);
      chk(tag_rx(exp_mode), "rx_hi_lvl", int'(rx_hi_lvl), exp_hi);
      chk(tag_rx(exp_mode), "rx_lo_lvl", int'(rx_lo_lvl), exp_lo);
      chk("R7", "fifo_depth", int'(fifo_depth), exp_dep);
      chk("R9", "tx_irq", int'(tx_irq), exp_tirq);
      chk("R10", "rx_irq", int'(rx_irq), exp_rirq);
    end
  end

  function automatic int clamp(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  // drive one set of inputs; fills placed around the thresholds they select
  task automatic apply(input int m, input bit e, input int f, input int ptx,
                       input int phi, input int plo, input int sel);
    int rt, rh;
    compat_mode = 3'(m);
    enh_mode    = e;
    fifo_ctl    = 8'(f);
    prog_tx_lvl = W'(ptx);
    prog_rx_hi  = W'(phi);
    prog_rx_lo  = W'(plo);
    rt = ref_tx(m, e, f, ptx);
    rh = ref_hi(m, f, phi);
    if (sel == 3) begin
      tx_fill = W'($urandom_range(0, 130));
      rx_fill = W'($urandom_range(0, 130));
    end else begin
      tx_fill = W'(clamp(rt + sel - 1));
      rx_fill = W'(clamp(rh + ((sel + 1) % 3) - 1));
    end
    tx_irq_en = (sel != 2) || f[1];
    rx_irq_en = (sel != 0) || f[2];
  endtask

  initial begin
    rst_n = 1'b0;
    apply(0, 1'b0, 0, 1, 1, 1, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tx_lvl", int'(tx_lvl), 0);
    chk("R1", "rx_hi_lvl", int'(rx_hi_lvl), 0);
    chk("R1", "rx_lo_lvl", int'(rx_lo_lvl), 0);
    chk("R1", "fifo_depth", int'(fifo_depth), 0);
    chk("R1", "tx_irq", int'(tx_irq), 0);
    chk("R1", "rx_irq", int'(rx_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_chk = 1'b1;

    // sweep of every mode code, flag value and control byte
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int f = 0; f < 256; f++) begin
          apply(m, e[0], f, 40 + f % 50, 20 + f % 100, 1 + f % 19, f % 3);
          @(negedge clk);
        end
      end
    end

    // R11: a change made between edges stays invisible until the next edge
    apply(5, 1'b1, 8'hFF, 77, 99, 9, 0);
    @(negedge clk);
    apply(5, 1'b1, 8'hFF, 33, 55, 5, 0);
    #1;
    chk("R11", "tx_lvl held", int'(tx_lvl), 77);
    chk("R11", "rx_hi_lvl held", int'(rx_hi_lvl), 99);
    @(negedge clk);
    #1;
    chk("R11", "tx_lvl updated", int'(tx_lvl), 33);

    // random mix, including mode changes with boundary fills in one cycle
    for (int i = 0; i < 2000; i++) begin
      apply($urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom_range(0, 255),
            $urandom_range(1, 127), $urandom_range(1, 127), $urandom_range(0, 127),
            $urandom_range(0, 3));
      @(negedge clk);
    end
    @(negedge clk);
    run_chk = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule